// File: doc/BRIEF.md
# Trace and Address-Error Exception Unit

This unit sits beside a processor core and decides, at the end of each instruction, whether the core must enter an exception. It handles two kinds. The first is a trace exception, raised after every instruction while the trace bit of the status register is set. The second is an address error, raised when the core touches the internal RAM window while that RAM is switched off in single-chip mode.

The unit owns the trace bit and the 3-bit interrupt mask of the status register. When it enters an exception it produces a one-cycle request with a cause code, plus the status image the core must push onto its stack. One cycle later it clears the live trace bit. The mask is never altered on entry, so interrupts can still be taken inside a trace handler. A return-from-exception strobe loads a popped status word back into the live register, which is how trace mode resumes after the handler.

The status word is 4 bits wide: bit 3 is the trace bit and bits 2:0 are the interrupt mask. The stack memory, vector fetch and instruction decode are outside this block.

Top module: `trace_aerr_unit`

## Requirements
- R1: With `single_chip`=1 and `ram_en`=0, an access with an address from 0xFB80 to 0xFF7F inclusive makes that instruction end in an address error (cause 2'b10). This holds whether the access comes in an earlier cycle of the instruction or in the same cycle as `instr_done`.
- R2: An access outside 0xFB80–0xFF7F (for example 0xFB7F or 0xFF80) never raises an address error. Neither does any access while `ram_en`=1 or `single_chip`=0.
- R3: While the live trace bit (status bit 3) is 1, every `instr_done` with no address error raises a trace request (cause 2'b01). While it is 0, no trace request is raised.
- R4: `exc_req` is high for exactly the one cycle after the `instr_done` cycle. `exc_cause` is 2'b01 for trace, 2'b10 for address error, and 2'b00 whenever `exc_req` is low.
- R5: On either exception, the live trace bit reads 0 from the cycle after `exc_req` is high.
- R6: Exception entry leaves the live interrupt mask (status bits 2:0) unchanged.
- R7: While `exc_req` is high, `stacked_sr` holds the live mask. Its trace bit is 1 for a trace request, and for an address error it equals the live trace bit as it was when the instruction completed.
- R8: A `rte_valid` pulse loads `rte_sr` into the live status register, visible the next cycle. If the loaded trace bit is 1, the next instruction is traced.
- R9: When an address error and a trace arise on the same instruction, only the address error is requested (cause 2'b10), and the live trace bit is then cleared.
- R10: After reset the live status register reads trace 0 and mask 3'b111, and `exc_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_done | input | 1 | One-cycle strobe marking instruction completion |
| acc_valid | input | 1 | A bus access happens this cycle |
| acc_addr | input | 16 | Address of the bus access |
| single_chip | input | 1 | 1 = single-chip mode, 0 = expanded mode |
| ram_en | input | 1 | Internal RAM enable control bit |
| rte_valid | input | 1 | Return-from-exception strobe |
| rte_sr | input | 4 | Popped status word: {trace, mask[2:0]} |
| exc_req | output | 1 | One-cycle exception request |
| exc_cause | output | 2 | 01 trace, 10 address error, 00 idle |
| stacked_sr | output | 4 | Status image to push, valid with `exc_req` |
| live_sr | output | 4 | Live status register {trace, mask[2:0]} |

## Verification
The assertions assume the core behaves like a core entering an exception. It raises no `instr_done` in the cycle that `exc_req` is high, and it sends no `rte_valid` in that cycle either. Under these assumptions a request is always one cycle wide, and the clear of the trace bit never collides with a status load. The stimulus follows every completing instruction with two idle cycles. It sends return strobes only while no request is in flight. It places window accesses both before and inside the `instr_done` cycle.

// File: rtl/taerr_pkg.sv
package taerr_pkg;
    localparam int ADDR_W = 16;
    localparam int MASK_W = 3;
    localparam int SR_W   = MASK_W + 1;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'b00,
        CAUSE_TRACE = 2'b01,
        CAUSE_AERR  = 2'b10
    } cause_e;

    typedef struct packed {
        logic              trace;
        logic [MASK_W-1:0] mask;
    } sr_t;

    localparam sr_t SR_RESET = {1'b0, {MASK_W{1'b1}}};

    function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] lo,
                                       input logic [ADDR_W-1:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction
endpackage

// File: rtl/taerr_addr_check.sv
module taerr_addr_check
    import taerr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WIN_LO = 16'hFB80,
    parameter logic [ADDR_W-1:0] WIN_HI = 16'hFF7F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              single_chip,
    input  logic              ram_en,
    input  logic              instr_done,
    output logic              fault_seen
);
    logic fault_now;
    logic pend_q;

    always_comb begin
        fault_now  = acc_valid && single_chip && !ram_en &&
                     in_window(acc_addr, WIN_LO, WIN_HI);
        fault_seen = pend_q || fault_now;
    end

    always_ff @(posedge clk) begin
        if (rst || instr_done) pend_q <= 1'b0;
        else if (fault_now)    pend_q <= 1'b1;
    end

    // A completing instruction always consumes the pending fault
    assert_pend_consumed_R1: assert property (@(posedge clk) disable iff (rst)
        instr_done |=> !pend_q);

    // Expanded mode never records a fault
    assert_no_fault_expanded_R2: assert property (@(posedge clk) disable iff (rst)
        (!single_chip && !pend_q) |=> !pend_q);
endmodule

// File: rtl/taerr_arbiter.sv
module taerr_arbiter
    import taerr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   instr_done,
    input  logic   fault_seen,
    input  sr_t    live,
    output logic   req,
    output cause_e cause,
    output sr_t    stacked
);
    logic   req_d;
    cause_e cause_d;
    sr_t    stacked_d;

    always_comb begin
        req_d     = 1'b0;
        cause_d   = CAUSE_NONE;
        stacked_d = stacked;
        if (instr_done) begin
            if (fault_seen) begin
                req_d     = 1'b1;
                cause_d   = CAUSE_AERR;
                stacked_d = live;
            end else if (live.trace) begin
                req_d     = 1'b1;
                cause_d   = CAUSE_TRACE;
                stacked_d = '{trace: 1'b1, mask: live.mask};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req     <= 1'b0;
            cause   <= CAUSE_NONE;
            stacked <= SR_RESET;
        end else begin
            req     <= req_d;
            cause   <= cause_d;
            stacked <= stacked_d;
        end
    end

    assert_cause_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !req |-> (cause == CAUSE_NONE));
    assert_cause_legal_R4: assert property (@(posedge clk) disable iff (rst)
        req |-> (cause == CAUSE_TRACE || cause == CAUSE_AERR));
    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        req |=> !req);
    assert_aerr_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (instr_done && fault_seen) |=> (req && cause == CAUSE_AERR));
    assert_trace_stacked_R7: assert property (@(posedge clk) disable iff (rst)
        (req && cause == CAUSE_TRACE) |-> (stacked.trace && stacked.mask == live.mask));
    assert_trace_raised_R3: assert property (@(posedge clk) disable iff (rst)
        (instr_done && live.trace) |=> req);
endmodule

// File: rtl/taerr_sr_reg.sv
module taerr_sr_reg
    import taerr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic entry,
    input  logic rte_valid,
    input  sr_t  rte_sr,
    output sr_t  live
);
    always_ff @(posedge clk) begin
        if (rst)            live <= SR_RESET;
        else if (entry)     live.trace <= 1'b0;
        else if (rte_valid) live <= rte_sr;
    end

    assert_entry_clears_R5: assert property (@(posedge clk) disable iff (rst)
        entry |=> !live.trace);
    assert_mask_kept_R6: assert property (@(posedge clk) disable iff (rst)
        entry |=> $stable(live.mask));
    assert_rte_loads_R8: assert property (@(posedge clk) disable iff (rst)
        (rte_valid && !entry) |=> (live == $past(rte_sr)));
    assert_reset_state_R10: assert property (@(posedge clk)
        rst |=> (live == SR_RESET));
endmodule

// File: rtl/trace_aerr_unit.sv
module trace_aerr_unit
    import taerr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WIN_LO = 16'hFB80,
    parameter logic [ADDR_W-1:0] WIN_HI = 16'hFF7F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_done,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              single_chip,
    input  logic              ram_en,
    input  logic              rte_valid,
    input  logic [SR_W-1:0]   rte_sr,
    output logic              exc_req,
    output logic [1:0]        exc_cause,
    output logic [SR_W-1:0]   stacked_sr,
    output logic [SR_W-1:0]   live_sr
);
    logic   fault_seen;
    sr_t    live;
    sr_t    stacked;
    cause_e cause;

    taerr_addr_check #(.WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_check (
        .clk         (clk),
        .rst         (rst),
        .acc_valid   (acc_valid),
        .acc_addr    (acc_addr),
        .single_chip (single_chip),
        .ram_en      (ram_en),
        .instr_done  (instr_done),
        .fault_seen  (fault_seen)
    );

    taerr_arbiter u_arb (
        .clk        (clk),
        .rst        (rst),
        .instr_done (instr_done),
        .fault_seen (fault_seen),
        .live       (live),
        .req        (exc_req),
        .cause      (cause),
        .stacked    (stacked)
    );

    taerr_sr_reg u_sr (
        .clk       (clk),
        .rst       (rst),
        .entry     (exc_req),
        .rte_valid (rte_valid),
        .rte_sr    (sr_t'(rte_sr)),
        .live      (live)
    );

    assign exc_cause  = cause;
    assign stacked_sr = stacked;
    assign live_sr    = live;

    assert_req_after_done_R4: assert property (@(posedge clk) disable iff (rst)
        exc_req |-> $past(instr_done));
endmodule

// File: tb/trace_aerr_unit_bench.sv
module trace_aerr_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_done = 1'b0;
    logic        acc_valid = 1'b0;
    logic [15:0] acc_addr = '0;
    logic        single_chip = 1'b1;
    logic        ram_en = 1'b0;
    logic        rte_valid = 1'b0;
    logic [3:0]  rte_sr = '0;
    logic        exc_req;
    logic [1:0]  exc_cause;
    logic [3:0]  stacked_sr;
    logic [3:0]  live_sr;

    int    total = 0;
    int    bad = 0;
    int    cycles = 0;
    bit    done_flag = 0;
    string phase = "R10";

    // reference model state
    bit       m_req, m_tr, m_pend;
    bit [1:0] m_cause;
    bit [2:0] m_mask;
    bit [3:0] m_stk;

    always #4 clk = ~clk;

    trace_aerr_unit u_trace_aerr_unit (
        .clk(clk), .rst(rst), .instr_done(instr_done), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .single_chip(single_chip), .ram_en(ram_en),
        .rte_valid(rte_valid), .rte_sr(rte_sr), .exc_req(exc_req),
        .exc_cause(exc_cause), .stacked_sr(stacked_sr), .live_sr(live_sr)
    );

    always @(posedge clk) begin
        bit f, n_req;
        bit [1:0] n_cause;
        bit [3:0] n_stk;
        if (rst) begin
            m_req = 0; m_cause = 0; m_tr = 0; m_mask = 3'b111; m_pend = 0; m_stk = 4'b0111;
        end else begin
            f = acc_valid && single_chip && !ram_en &&
                acc_addr >= 16'hFB80 && acc_addr <= 16'hFF7F;
            n_req = 0; n_cause = 0; n_stk = m_stk;
            if (instr_done) begin
                if (m_pend || f) begin
                    n_req = 1; n_cause = 2'b10; n_stk = {m_tr, m_mask};
                end else if (m_tr) begin
                    n_req = 1; n_cause = 2'b01; n_stk = {1'b1, m_mask};
                end
            end
            if (instr_done) m_pend = 0;
            else if (f)     m_pend = 1;
            if (m_req)          m_tr = 0;
            else if (rte_valid) {m_tr, m_mask} = rte_sr;
            m_req = n_req; m_cause = n_cause; m_stk = n_stk;
        end
    end

    task automatic check(input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", phase, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #2;
        cycles++;
        check("exc_req", exc_req, m_req);
        check("exc_cause", exc_cause, m_cause);
        check("live_sr", live_sr, {m_tr, m_mask});
        if (m_req) check("stacked_sr", stacked_sr, m_stk);
    end

    task automatic cyc(input bit d, input bit av, input logic [15:0] a);
        @(negedge clk);
        instr_done = d; acc_valid = av; acc_addr = a; rte_valid = 0;
    endtask

    // one instruction: optional access, completion, two idle cycles
    task automatic instr(input bit av, input logic [15:0] a, input bit early);
        if (early) begin
            cyc(0, av, a);
            cyc(1, 0, 16'h0000);
        end else begin
            cyc(1, av, a);
        end
        cyc(0, 0, 16'h0000);
        cyc(0, 0, 16'h0000);
    endtask

    task automatic rte(input logic [3:0] sr);
        @(negedge clk);
        instr_done = 0; acc_valid = 0; rte_valid = 1; rte_sr = sr;
        @(negedge clk);
        rte_valid = 0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        wait (cycles > 20000);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        phase = "R10";
        rst = 0;
        @(negedge clk);
        phase = "R3";
        instr(0, 16'h1000, 0);           // trace off: no request
        phase = "R8";
        rte(4'b1_101);                    // restore with trace set
        phase = "R3";
        instr(1, 16'h2000, 0);           // traced
        phase = "R5";
        instr(0, 16'h0000, 0);           // trace now cleared: no request
        phase = "R8";
        rte(4'b1_010);
        phase = "R6";
        instr(0, 16'h0000, 0);           // traced, mask 010 kept
        phase = "R1";
        instr(1, 16'hFB80, 0);
        instr(1, 16'hFF7F, 1);
        instr(1, 16'hFD00, 1);
        phase = "R2";
        instr(1, 16'hFB7F, 0);
        instr(1, 16'hFF80, 0);
        ram_en = 1;
        instr(1, 16'hFC00, 0);
        ram_en = 0; single_chip = 0;
        instr(1, 16'hFC00, 1);
        single_chip = 1;
        phase = "R9";
        rte(4'b1_011);
        instr(1, 16'hFE00, 0);           // both: address error wins
        instr(0, 16'h0000, 0);           // trace cleared: no request
        phase = "R7";
        rte(4'b1_100);
        instr(1, 16'hFB90, 1);           // stacked trace bit 1 for address error
        rte(4'b1_001);
        instr(0, 16'h0000, 0);
        phase = "R4";
        rte(4'b1_111);
        for (int i = 0; i < 6; i++) begin
            rte(4'b1_111);
            instr(i % 2 == 0, 16'hFB80 + 16'(i * 16'h100), i % 3 == 0);
        end
        phase = "R10";
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        repeat (3) @(negedge clk);
        done_flag = 1;
        finish_run();
    end
endmodule